// File: doc/BRIEF.md
# Parity-Preserving Carry Look-Ahead Adder

This block adds two 4-bit operands and a carry-in. It forms every internal carry from AND/XOR product terms rather than from a ripple chain. The datapath is built only from two kinds of three-in/three-out parity-preserving primitives:

- a double-XOR copier, which also serves as a fan-out element;
- a controlled swap, which also serves as an AND gate.

Each look-ahead carry is a sum of products in which no two products can be 1 at the same time. So every OR in the carry equations is an XOR, and the whole adder maps onto these reversible-style cells.

Every cell output is either consumed by exactly one cell input or leaves the block. Unused cell outputs are garbage. The block folds the parity of all primary inputs, constant inputs, functional outputs and garbage into a single mismatch flag. On fault-free logic this flag is always 0.

A fault-injection mask can invert any functional output bit, so the detection path can be exercised. The low half of the adder (sum bits 1:0 and the carry into bit 2) is also exposed as a 2-bit sub-result.

Top module: `pp_cla_adder`

## Requirements
- R1: For every bit, the propagate signal is the XOR of the operand bits and the generate signal is their AND. The two are never 1 together.
- R2: With a zero fault mask, {carry_o, s_o} equals a_i + b_i + c0_i as a 5-bit unsigned value.
- R3: With a zero fault mask, {sub_c_o, sub_s_o} equals a_i[1:0] + b_i[1:0] + c0_i as a 3-bit unsigned value. sub_c_o is the carry into bit 2.
- R4: In the look-ahead expression of each carry, at most one product term is 1 for any input. This makes the XOR combination of the terms exact.
- R5: With a zero fault mask, par_err_o is 0 for all 512 combinations of a_i, b_i and c0_i.
- R6: Fault-mask bits 3:0 invert s_o[3:0] one for one, and bit 4 inverts carry_o. The inversion of s_o[1:0] is also seen on sub_s_o. sub_c_o is never affected by the mask.
- R7: A fault mask of odd weight drives par_err_o to 1. A mask of even weight leaves par_err_o at 0, because it is undetectable by a single parity.
- R8: Each primitive cell preserves parity between its three inputs and three outputs. The swap cell also preserves the number of ones.
- R9: The block is purely combinational. Every output follows a change at the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| c0_i | input | 1 | Carry-in |
| flt_mask_i | input | 5 | Fault injection: bits 3:0 invert sum bits, bit 4 inverts the carry-out |
| s_o | output | 4 | Sum |
| carry_o | output | 1 | Carry-out of bit 3 |
| sub_s_o | output | 2 | Sum of the 2-bit low sub-adder |
| sub_c_o | output | 1 | Carry-out of the 2-bit low sub-adder |
| par_err_o | output | 1 | Parity mismatch over inputs, constants, outputs and garbage |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench changes the inputs one time unit after a rising clock edge and compares all outputs at the following falling edge. All logic has settled by then, and no comparison ever coincides with an input change. One scenario sets new inputs and reads the outputs after a single time unit, without waiting for any edge, to show that nothing is held by a register.

// File: rtl/pp_cla_pkg.sv
package pp_cla_pkg;

  parameter int unsigned CLA_W_DEF = 4;

  // start of column i inside the packed triangle of forwarded term copies
  function automatic int unsigned tri_off(input int unsigned i);
    return (i * (i + 3)) / 2;
  endfunction

endpackage

// File: rtl/ppg_f2.sv
// double-XOR copier: x = a, y = a ^ b, z = a ^ c
module ppg_f2 (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic x_o,
  output logic y_o,
  output logic z_o
);

  assign x_o = a_i;
  assign y_o = a_i ^ b_i;
  assign z_o = a_i ^ c_i;

  always_comb begin
    // R8
    f2_par_chk: assert ((a_i ^ b_i ^ c_i) == (x_o ^ y_o ^ z_o))
      else $error("f2 cell parity broken");
  end

endmodule

// File: rtl/ppg_fr.sv
// controlled swap: a passes, b and c swap when a is 1
module ppg_fr (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic x_o,
  output logic y_o,
  output logic z_o
);

  assign x_o = a_i;
  assign y_o = a_i ? c_i : b_i;
  assign z_o = a_i ? b_i : c_i;

  always_comb begin
    // R8
    fr_par_chk: assert ((a_i ^ b_i ^ c_i) == (x_o ^ y_o ^ z_o))
      else $error("swap cell parity broken");
    // R8
    fr_ones_chk: assert ($countones({a_i, b_i, c_i}) == $countones({x_o, y_o, z_o}))
      else $error("swap cell ones count broken");
  end

endmodule

// File: rtl/pp_bit_pg.sv
// per-bit propagate/generate from two parity-preserving cells
module pp_bit_pg (
  input  logic a_i,
  input  logic b_i,
  output logic p_o,
  output logic g_o,
  output logic gar_o
);

  logic a_g, p_w, a_cp, a_nb;

  ppg_f2 u_xor (
    .a_i (a_i),
    .b_i (b_i),
    .c_i (1'b0),
    .x_o (a_g),
    .y_o (p_w),
    .z_o (a_cp)
  );

  // with c = 0: y = ~p & a = a & b, z = p & a
  ppg_fr u_and (
    .a_i (p_w),
    .b_i (a_cp),
    .c_i (1'b0),
    .x_o (p_o),
    .y_o (g_o),
    .z_o (a_nb)
  );

  assign gar_o = a_g ^ a_nb;

  always_comb begin
    // R1
    gp_excl_chk: assert (!(g_o && p_o))
      else $error("generate and propagate both high");
  end

endmodule

// File: rtl/pp_carry_col.sv
// look-ahead column IDX: produces c[IDX+1] from IDX+2 exclusive product terms
module pp_carry_col #(
  parameter int unsigned IDX = 0
) (
  input  logic           p_i,
  input  logic           g_i,
  input  logic [IDX:0]   prev_i,
  output logic           p_o,
  output logic           carry_o,
  output logic [IDX+1:0] tcp_o,
  output logic           gar_o
);

  localparam int unsigned N_TERM = IDX + 2;

  logic [IDX+1:0]  pth;
  logic [IDX+1:0]  term;
  logic [IDX:0]    and_gar;
  logic [N_TERM:0] acc;
  logic [IDX+1:0]  acc_gar;

  assign pth[0]     = p_i;
  assign acc[0]     = 1'b0;
  assign term[IDX+1] = g_i;

  // extend each previous-column term by P[IDX]; P threads through the control line
  for (genvar k = 0; k <= IDX; k++) begin : g_and
    ppg_fr u_and (
      .a_i (pth[k]),
      .b_i (prev_i[k]),
      .c_i (1'b0),
      .x_o (pth[k+1]),
      .y_o (and_gar[k]),
      .z_o (term[k])
    );
  end

  // XOR-accumulate the terms; the copy output forwards each term to the next column
  for (genvar k = 0; k < N_TERM; k++) begin : g_acc
    ppg_f2 u_acc (
      .a_i (term[k]),
      .b_i (acc[k]),
      .c_i (1'b0),
      .x_o (tcp_o[k]),
      .y_o (acc[k+1]),
      .z_o (acc_gar[k])
    );
  end

  assign p_o     = pth[IDX+1];
  assign carry_o = acc[N_TERM];
  assign gar_o   = (^and_gar) ^ (^acc_gar);

  always_comb begin
    // R4
    term_excl_chk: assert ($countones(term) <= 1)
      else $error("carry product terms overlap in column %0d", IDX);
  end

endmodule

// File: rtl/pp_cla_adder.sv
module pp_cla_adder
  import pp_cla_pkg::*;
#(
  parameter int unsigned WIDTH = CLA_W_DEF
) (
  input  logic [WIDTH-1:0]        a_i,
  input  logic [WIDTH-1:0]        b_i,
  input  logic                    c0_i,
  input  logic [WIDTH:0]          flt_mask_i,
  output logic [WIDTH-1:0]        s_o,
  output logic                    carry_o,
  output logic [(WIDTH/2)-1:0]    sub_s_o,
  output logic                    sub_c_o,
  output logic                    par_err_o
);

  localparam int unsigned SUB_W    = WIDTH / 2;
  localparam int unsigned TRI      = tri_off(WIDTH);
  localparam int unsigned LAST_OFF = tri_off(WIDTH - 1);

  logic [WIDTH-1:0] p_raw, p_fin, g;
  logic [WIDTH-1:0] gar_pg, gar_col, gar_sum;
  logic [WIDTH-1:0] sum_x, sum_z, s_raw;
  logic [WIDTH:0]   cy;
  logic [TRI-1:0]   tcp;
  logic             c0_chain, c0_gar;

  // explicit three-way fan-out of the carry-in
  ppg_f2 u_c0_dup (
    .a_i (c0_i),
    .b_i (1'b0),
    .c_i (1'b0),
    .x_o (cy[0]),
    .y_o (c0_chain),
    .z_o (c0_gar)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int unsigned OFF = tri_off(i);
    logic [i:0] prev_w;

    pp_bit_pg u_pg (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .p_o   (p_raw[i]),
      .g_o   (g[i]),
      .gar_o (gar_pg[i])
    );

    if (i == 0) begin : g_first
      assign prev_w = c0_chain;
    end else begin : g_next
      assign prev_w = tcp[tri_off(i-1) +: i+1];
    end

    pp_carry_col #(.IDX(i)) u_col (
      .p_i     (p_raw[i]),
      .g_i     (g[i]),
      .prev_i  (prev_w),
      .p_o     (p_fin[i]),
      .carry_o (cy[i+1]),
      .tcp_o   (tcp[OFF +: i+2]),
      .gar_o   (gar_col[i])
    );

    // sum cell: y = c ^ p, and both copies of c are kept
    ppg_f2 u_sum (
      .a_i (cy[i]),
      .b_i (p_fin[i]),
      .c_i (1'b0),
      .x_o (sum_x[i]),
      .y_o (s_raw[i]),
      .z_o (sum_z[i])
    );

    // the copy of c[SUB_W] is the sub-adder carry rather than garbage
    if (i == SUB_W) begin : g_sub_tap
      assign gar_sum[i] = sum_x[i];
    end else begin : g_plain
      assign gar_sum[i] = sum_x[i] ^ sum_z[i];
    end
  end

  assign s_o     = s_raw ^ flt_mask_i[WIDTH-1:0];
  assign carry_o = cy[WIDTH] ^ flt_mask_i[WIDTH];
  assign sub_s_o = s_o[SUB_W-1:0];
  assign sub_c_o = sum_z[SUB_W];

  // constant inputs are all zero and add nothing to the input side
  assign par_err_o = ^{a_i, b_i, c0_i, s_o, carry_o, sub_c_o,
                       gar_pg, gar_col, gar_sum, c0_gar,
                       tcp[LAST_OFF +: WIDTH+1]};

  always_comb begin
    if (flt_mask_i == '0) begin
      // R2
      sum_match_chk: assert ({carry_o, s_o} ==
                             ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c0_i}))
        else $error("sum/carry mismatch");
      // R3
      sub_match_chk: assert ({sub_c_o, sub_s_o} ==
                             ({1'b0, a_i[SUB_W-1:0]} + {1'b0, b_i[SUB_W-1:0]} +
                              {{SUB_W{1'b0}}, c0_i}))
        else $error("sub-adder mismatch");
      // R5
      par_clean_chk: assert (!par_err_o)
        else $error("parity flag raised without fault");
    end
  end

endmodule

// File: tb/pp_cla_adder_tb.sv
module pp_cla_adder_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [3:0] a, b;
  logic       c0;
  logic [4:0] mask;
  logic [3:0] s;
  logic       carry;
  logic [1:0] sub_s;
  logic       sub_c;
  logic       par_err;

  int  n_cmp  = 0;
  int  n_bad  = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_cla_adder u_dut (
    .a_i        (a),
    .b_i        (b),
    .c0_i       (c0),
    .flt_mask_i (mask),
    .s_o        (s),
    .carry_o    (carry),
    .sub_s_o    (sub_s),
    .sub_c_o    (sub_c),
    .par_err_o  (par_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h (a=%0h b=%0h c0=%0b mask=%0h)",
               req, act, exp, a, b, c0, mask);
    end
  endtask

  // inputs change after the rising edge, outputs are read at the falling edge
  task automatic apply(input int av, input int bv, input int cv, input int mv);
    @(posedge clk);
    #1;
    a = 4'(av); b = 4'(bv); c0 = 1'(cv); mask = 5'(mv);
    @(negedge clk);
  endtask

  task automatic t_initial;
    apply(0, 0, 0, 0);
    check("R2 zero sum", {27'd0, carry, s}, 0);
    check("R3 zero sub", {29'd0, sub_c, sub_s}, 0);
    check("R5 zero flag", {31'd0, par_err}, 0);
  endtask

  task automatic t_exhaustive;
    for (int av = 0; av < 16; av++)
      for (int bv = 0; bv < 16; bv++)
        for (int cv = 0; cv < 2; cv++) begin
          apply(av, bv, cv, 0);
          check("R2 full sum", {27'd0, carry, s}, av + bv + cv);
          check("R3 low sum", {29'd0, sub_c, sub_s}, (av % 4) + (bv % 4) + cv);
          check("R5 R8 clean parity", {31'd0, par_err}, 0);
        end
  endtask

  task automatic t_corners;
    // R4: carry-in travels through four propagates (c0 product term alone)
    apply(15, 0, 1, 0);
    check("R4 full propagate", {27'd0, carry, s}, 16);
    // R4: top generate only
    apply(8, 8, 0, 0);
    check("R4 top generate", {27'd0, carry, s}, 16);
    // R1: generate and propagate in the same operand pair
    apply(4'b1010, 4'b1100, 0, 0);
    check("R1 mixed pg", {27'd0, carry, s}, 10 + 12);
    apply(15, 15, 1, 0);
    check("R2 max", {27'd0, carry, s}, 31);
    check("R3 max low", {29'd0, sub_c, sub_s}, 7);
    apply(3, 1, 0, 0);
    check("R3 low carry into bit 2", {31'd0, sub_c}, 1);
  endtask

  task automatic t_single_mask;
    int vec [3][3] = '{'{5, 9, 1}, '{0, 0, 0}, '{15, 15, 1}};
    for (int v = 0; v < 3; v++)
      for (int m = 0; m < 5; m++) begin
        int ref_sum;
        ref_sum = vec[v][0] + vec[v][1] + vec[v][2];
        apply(vec[v][0], vec[v][1], vec[v][2], 1 << m);
        check("R6 single flip", {27'd0, carry, s}, ref_sum ^ (1 << m));
        check("R6 sub carry untouched", {31'd0, sub_c},
              ((vec[v][0] % 4) + (vec[v][1] % 4) + vec[v][2]) / 4);
        check("R6 sub sum follows mask", {30'd0, sub_s}, (ref_sum ^ (1 << m)) % 4);
        check("R7 odd detected", {31'd0, par_err}, 1);
      end
  endtask

  task automatic t_multi_mask;
    int masks [4] = '{5'b00011, 5'b10001, 5'b00111, 5'b11111};
    for (int m = 0; m < 4; m++) begin
      apply(6, 7, 1, masks[m]);
      check("R6 multi flip", {27'd0, carry, s}, 14 ^ masks[m]);
      check("R7 weight parity", {31'd0, par_err}, $countones(masks[m]) % 2);
    end
  endtask

  task automatic t_comb;
    @(posedge clk);
    #1;
    a = 4'd9; b = 4'd6; c0 = 1'b1; mask = 5'd0;
    #1;
    check("R9 same-cycle sum", {27'd0, carry, s}, 16);
    a = 4'd2;
    #1;
    check("R9 immediate follow", {27'd0, carry, s}, 9);
    check("R9 immediate flag", {31'd0, par_err}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; c0 = 1'b0; mask = '0;
    t_initial();
    t_exhaustive();
    t_corners();
    t_single_mask();
    t_multi_mask();
    t_comb();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule